// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit is the protection core of a serial nonvolatile byte memory slave. It holds the write enable latch and the persistent configuration bits: a pin-lock enable and a two-bit block-protect code. It makes every decision about whether a write may proceed. The command decoder gives it single-cycle strobes for the commands. It also gives it the data byte for a status write, the active-low write-protect pin and a candidate byte address. The unit returns the status byte for reading, a flag saying whether a status write would be accepted now, and a flag saying whether a byte write to the candidate address would be accepted now.

Protection works in tiers. A write is possible only after the latch has been set. The latch drops by itself when chip select ends a cycle in which a write actually completed. The block-protect code fences off an upper fraction of the array. The pin-lock enable lets the hardware pin freeze the status register, so that the protection setting cannot be changed by software alone. The persistent bits are plain registers with a reset value of zero. Serial shifting and real nonvolatile storage belong to other blocks.

Top module: `wprot_unit`

## Requirements
- R1: The status byte carries the pin-lock enable in bit 7, the block-protect code in bits 3:2 and the latch in bit 1. Bits 6:4 and bit 0 always read 0, and a status write whose data has ones there leaves them at 0.
- R2: After reset the latch, the pin-lock enable and the block-protect code are all 0, so the status byte reads 00h and both permission flags are 0.
- R3: A set strobe (`set_we`) sets the latch and a clear strobe (`clr_we`) clears it, one cycle later. When both arrive in the same cycle, the clear wins.
- R4: A status write never changes the latch. Bit 1 of the written data is ignored.
- R5: An end-of-cycle strobe (`cyc_end`) clears the latch only if a write completed since the latch was last set. An end-of-cycle strobe with no completed write leaves the latch as it was.
- R6: `stat_wr_ok` is 1 exactly when the latch is 1 and not (pin-lock enable = 1 and `wp_n` = 0). A status write strobe while it is 0 changes no status bit and does not count as a completed write.
- R7: The protected range is chosen by the block-protect code. Code 0 protects nothing. Code 1 protects 1800h–1FFFh. Code 2 protects 1000h–1FFFh. Code 3 protects 0000h–1FFFh.
- R8: `mem_wr_ok` is 1 exactly when the latch is 1 and `waddr` lies outside the protected range. `wp_n` has no effect on it.
- R9: A byte-write strobe (`mem_wr`) counts as a completed write only if `mem_wr_ok` was 1 in that cycle. A refused byte write does not arm the end-of-cycle clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_we | input | 1 | Strobe: set the write enable latch |
| clr_we | input | 1 | Strobe: clear the write enable latch |
| stat_wr | input | 1 | Strobe: status write with `stat_din` |
| stat_din | input | 8 | Data byte for a status write |
| mem_wr | input | 1 | Strobe: a byte is being committed at `waddr` |
| cyc_end | input | 1 | Strobe: chip select rose, ending the cycle |
| wp_n | input | 1 | Write-protect pin, active low |
| waddr | input | 13 | Candidate byte address |
| stat_dout | output | 8 | Status byte |
| stat_wr_ok | output | 1 | A status write would be accepted now |
| mem_wr_ok | output | 1 | A byte write to `waddr` would be accepted now |

## Verification
The assertions check these rules on every cycle:
- the latch follows set and clear strobes, with clear taking priority;
- a status write leaves the latch alone;
- a refused status write freezes the persistent bits;
- the pin lock and the full-array code each force their flag low.

Some behaviour only the bench's scenarios can show:
- the exact boundary addresses of each protected range;
- that an end-of-cycle strobe clears the latch after a completed write but not after refused ones;
- that reserved bits stay zero when ones are written to them.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   localparam int STAT_W     = 8;
   localparam int POS_LOCK   = 7;
   localparam int POS_BP_HI  = 3;
   localparam int POS_BP_LO  = 2;
   localparam int POS_LATCH  = 1;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] bp;
   } nv_cfg_t;

   function automatic logic [STAT_W-1:0] pack_status(input nv_cfg_t cfg, input logic latch);
      logic [STAT_W-1:0] s;
      s = '0;
      s[POS_LOCK]              = cfg.lock_en;
      s[POS_BP_HI:POS_BP_LO]   = cfg.bp;
      s[POS_LATCH]             = latch;
      return s;
   endfunction

   function automatic nv_cfg_t unpack_cfg(input logic [STAT_W-1:0] d);
      nv_cfg_t c;
      c.lock_en = d[POS_LOCK];
      c.bp      = d[POS_BP_HI:POS_BP_LO];
      return c;
   endfunction
endpackage

// File: rtl/wprot_latch.sv
module wprot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_we,
   input  logic clr_we,
   input  logic commit,
   input  logic cyc_end,
   output logic latch
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (clr_we || (cyc_end && armed)) latch <= 1'b0;
         else if (set_we)                  latch <= 1'b1;

         if (cyc_end || clr_we || set_we) armed <= 1'b0;
         else if (commit)                 armed <= 1'b1;
      end
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> !latch); // R3
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we && !cyc_end) |=> latch); // R3
   AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && armed) |=> !latch); // R5
   AST_IDLE_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !armed && !set_we && !clr_we) |=> (latch == $past(latch))); // R5
endmodule

// File: rtl/wprot_cfg.sv
module wprot_cfg
   import wprot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] din,
   output nv_cfg_t           cfg
);
   localparam nv_cfg_t CFG_RST = '{lock_en: 1'b0, bp: 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg <= CFG_RST;
      else if (wr_en) cfg <= unpack_cfg(din);
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg)); // R6
endmodule

// File: rtl/wprot_region.sv
module wprot_region #(
   parameter int ADDR_W = 13,
   parameter int STYLE  = 0
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              fenced
);
   localparam logic [ADDR_W-1:0] LB_QTR  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] LB_HALF = {1'b1,  {(ADDR_W-1){1'b0}}};

   if (ADDR_W < 2) begin : g_bad_w
      $error("wprot_region: ADDR_W must be at least 2");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_bad_s
      $error("wprot_region: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_topbits
      always_comb begin
         unique case (bp)
            2'b00:   fenced = 1'b0;
            2'b01:   fenced = addr[ADDR_W-1] & addr[ADDR_W-2];
            2'b10:   fenced = addr[ADDR_W-1];
            default: fenced = 1'b1;
         endcase
      end
   end else begin : g_bound
      logic [ADDR_W-1:0] lb;
      always_comb begin
         unique case (bp)
            2'b01:   lb = LB_QTR;
            2'b10:   lb = LB_HALF;
            default: lb = '0;
         endcase
         fenced = (bp != 2'b00) && (addr >= lb);
      end
   end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
   import wprot_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int REGION_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic              stat_wr,
   input  logic [STAT_W-1:0] stat_din,
   input  logic              mem_wr,
   input  logic              cyc_end,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] waddr,
   output logic [STAT_W-1:0] stat_dout,
   output logic              stat_wr_ok,
   output logic              mem_wr_ok
);
   logic    latch;
   logic    fenced;
   logic    stat_take;
   logic    mem_take;
   nv_cfg_t cfg;

   assign stat_wr_ok = latch && !(cfg.lock_en && !wp_n);
   assign mem_wr_ok  = latch && !fenced;
   assign stat_take  = stat_wr && stat_wr_ok;
   assign mem_take   = mem_wr && mem_wr_ok;
   assign stat_dout  = pack_status(cfg, latch);

   wprot_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (set_we),
      .clr_we  (clr_we),
      .commit  (stat_take || mem_take),
      .cyc_end (cyc_end),
      .latch   (latch)
   );

   wprot_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (stat_take),
      .din   (stat_din),
      .cfg   (cfg)
   );

   wprot_region #(.ADDR_W(ADDR_W), .STYLE(REGION_STYLE)) u_region (
      .bp     (cfg.bp),
      .addr   (waddr),
      .fenced (fenced)
   );

   AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_dout[POS_LOCK] && !wp_n) |-> !stat_wr_ok); // R6
   AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_dout[POS_BP_HI:POS_BP_LO] == 2'b11) |-> !mem_wr_ok); // R7
   AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_dout[POS_LATCH] |-> (!mem_wr_ok && !stat_wr_ok)); // R8
   AST_STATWR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !set_we && !clr_we && !cyc_end) |=>
         (stat_dout[POS_LATCH] == $past(stat_dout[POS_LATCH]))); // R4
endmodule

// File: tb/sim_wprot_unit.sv
module sim_wprot_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_we = 0, clr_we = 0, stat_wr = 0, mem_wr = 0, cyc_end = 0;
   logic        wp_n = 1'b1;
   logic [7:0]  stat_din = '0;
   logic [12:0] waddr = '0;
   logic [7:0]  stat_dout;
   logic        stat_wr_ok, mem_wr_ok;
   int          n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   wprot_unit u0 (.*);

   // {bp[1:0], addr[12:0], expected mem_wr_ok}
   localparam logic [15:0] VEC [12] = '{
      {2'b00, 13'h0000, 1'b1}, {2'b00, 13'h1FFF, 1'b1},
      {2'b01, 13'h17FF, 1'b1}, {2'b01, 13'h1800, 1'b0},
      {2'b01, 13'h1FFF, 1'b0}, {2'b01, 13'h0000, 1'b1},
      {2'b10, 13'h0FFF, 1'b1}, {2'b10, 13'h1000, 1'b0},
      {2'b10, 13'h1FFF, 1'b0}, {2'b11, 13'h0000, 1'b0},
      {2'b11, 13'h0FFF, 1'b0}, {2'b11, 13'h1FFF, 1'b0}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive on the falling edge, held for one rising edge, results seen at next falling edge
   task automatic step();
      @(negedge clk);
      set_we = 0; clr_we = 0; stat_wr = 0; mem_wr = 0; cyc_end = 0;
   endtask
   task automatic do_set();  set_we = 1; step(); endtask
   task automatic do_clr();  clr_we = 1; step(); endtask
   task automatic do_end();  cyc_end = 1; step(); endtask
   task automatic do_stat(input logic [7:0] d); stat_din = d; stat_wr = 1; step(); endtask

   initial begin : watchdog
      #100000;
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R2 reset status", stat_dout, 8'h00);
      chk("R2 reset flags", {6'b0, stat_wr_ok, mem_wr_ok}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R7 R8 ranges, wp_n low has no effect on array writes (lock_en 0)
      foreach (VEC[i]) begin
         do_set();
         do_stat({4'b0000, VEC[i][15:14], 2'b00});
         do_end();
         do_set();
         waddr = VEC[i][13:1];
         wp_n  = i[0];
         @(posedge clk); @(negedge clk);
         chk($sformatf("R7/R8 vec %0d", i), {7'b0, mem_wr_ok}, {7'b0, VEC[i][0]});
         wp_n = 1'b1;
      end
      do_clr();
      chk("R8 no latch, no write", {7'b0, mem_wr_ok}, 8'h00);

      // back to bp=0
      do_set(); do_stat(8'h00); do_end();
      chk("R5 end after status write clears latch", stat_dout, 8'h00);

      do_set();
      chk("R3 set latch", stat_dout, 8'h02);
      do_clr();
      chk("R3 clear latch", stat_dout, 8'h00);
      set_we = 1; clr_we = 1; step();
      chk("R3 clear wins", stat_dout, 8'h00);

      do_set();
      do_stat(8'hFF);
      chk("R1 R4 reserved zero, latch kept", stat_dout, 8'h8E);
      do_end();
      chk("R5 latch dropped", stat_dout, 8'h8C);

      // pin lock
      wp_n = 1'b0;
      do_set();
      chk("R6 locked flag", {7'b0, stat_wr_ok}, 8'h00);
      do_stat(8'h00);
      chk("R6 refused write keeps bits", stat_dout, 8'h8E);
      do_end();
      chk("R9 refused status write does not arm", stat_dout, 8'h8E);
      wp_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R6 unlocked flag", {7'b0, stat_wr_ok}, 8'h01);
      do_stat(8'h00);
      chk("R6 accepted write", stat_dout, 8'h02);

      // idle end keeps latch; byte write commit
      do_end();
      chk("R5 end after accepted write", stat_dout, 8'h00);
      do_set();
      do_end();
      chk("R5 idle end keeps latch", stat_dout, 8'h02);
      waddr = 13'h0005; mem_wr = 1; step();
      do_end();
      chk("R9 accepted byte arms clear", stat_dout, 8'h00);

      // refused byte write (bp=01 region)
      do_set(); do_stat(8'h04); do_end();
      do_set();
      waddr = 13'h1900; mem_wr = 1; step();
      do_end();
      chk("R9 refused byte does not arm", stat_dout, 8'h06);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule